// File: doc/BRIEF.md
# Linked Transport-Key Classifier

This block is the transport-layer stage of a receive classification chain. An earlier stage has already matched the packet's network-layer header and hands over a small record: the handle of the entry it matched, a key kind, and a 32-bit key value. For ordinary UDP or TCP traffic the key is the destination port. For tunnelled user-plane traffic carried over UDP it is the 32-bit tunnel endpoint identifier. The block searches a small associative table in parallel and returns a routing record. The record holds a destination class, a flow id, a queue number, a multi-route index and two software-info words.

Each table entry is chained to one earlier-stage handle. An entry hits only when the handle, the key kind and the key all agree with the request. A request that hits nothing receives a programmable default route. A command port adds entries, deletes them by index and replaces the default route. Each command returns a status code and an entry index one cycle later.

The request and result sides are valid/ready streams. A request transfers on a rising edge where `in_valid` and `in_ready` are both high. The producer must hold `in_valid` and the request fields steady until that edge. A result transfers on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the result stays put and `in_ready` drops once the internal stage behind it is occupied. The command side always accepts (`cmd_ready` is tied high). Its response is a one-cycle pulse with no back-pressure.

Top module: `l4_link_classifier`

## Requirements
- R1: With key kind 0 (port), only bits 15:0 of the key take part. Bits 31:16 are ignored both when an entry is added and when a request is looked up.
- R2: With key kind 1 (tunnel id), all 32 key bits take part. An entry of one kind never hits a request of the other kind.
- R3: A request hits an entry only if its link handle equals the handle stored in that entry.
- R4: On a hit, `out_hit` is 1, `out_index` is the entry's slot, and the route fields equal the ones stored by the entry's most recent add. The destination codes are 0 host, 1 Ethernet egress, 2 crypto engine 0, 3 crypto engine 1, 4 discard and 5 continue parsing; they are returned exactly as stored.
- R5: On a miss, `out_hit` is 0, `out_index` is 0, and the route equals the default route. After reset the default route is destination 4, flow 0, queue 0, multi-route all ones (none), and both software words 0. Op 2 replaces the default route and responds status 0.
- R6: Op 0 (add) with a key not yet present fills the lowest-numbered free slot. It responds status 0 (ok) with that slot as the index.
- R7: An add whose handle, kind and key equal an existing entry rewrites that entry's route in place. It responds status 0 with the existing slot and consumes no free slot.
- R8: An add of a new key when every slot is occupied responds status 1 (table full) with index 0 and leaves the table unchanged.
- R9: Op 1 (delete) on an occupied slot frees it and responds status 0; that entry no longer hits. A delete on a free slot responds status 2 (not found).
- R10: With `out_ready` high, a request accepted on one rising edge is presented on `out_valid` after the following rising edge. Results leave in request order.
- R11: While `out_valid` is 1 and `out_ready` is 0, every output field holds steady. After one more request is accepted, `in_ready` is 0.
- R12: Each command cycle produces `rsp_valid` for exactly the next cycle. Op 3 is reserved, responds status 3, and changes nothing.
- R13: After reset `out_valid` and `rsp_valid` are 0, `in_ready` is 1, and every slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_link | input | LINK_W | Earlier-stage match handle |
| in_kind | input | 1 | Key kind: 0 port, 1 tunnel id |
| in_key | input | 32 | Key value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | 1 when an entry matched |
| out_index | output | IW | Slot of the matched entry, 0 on a miss |
| out_dest | output | 3 | Destination class |
| out_flow | output | FLOW_W | Flow id |
| out_queue | output | QUEUE_W | Queue number |
| out_mroute | output | MR_W | Multi-route index, all ones means none |
| out_sw0 | output | 32 | Software-info word 0 |
| out_sw1 | output | 32 | Software-info word 1 |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always 1 |
| cmd_op | input | 2 | 0 add, 1 delete, 2 set default, 3 reserved |
| cmd_index | input | IW | Slot for delete |
| cmd_link | input | LINK_W | Handle for add |
| cmd_kind | input | 1 | Key kind for add |
| cmd_key | input | 32 | Key for add |
| cmd_dest | input | 3 | Route destination for add or set default |
| cmd_flow | input | FLOW_W | Route flow id |
| cmd_queue | input | QUEUE_W | Route queue |
| cmd_mroute | input | MR_W | Route multi-route index |
| cmd_sw0 | input | 32 | Route software word 0 |
| cmd_sw1 | input | 32 | Route software word 1 |
| rsp_valid | output | 1 | Command response present, one cycle |
| rsp_status | output | 2 | 0 ok, 1 table full, 2 not found, 3 bad op |
| rsp_index | output | IW | Slot written or deleted |

## Verification
The properties assume that the table is written only through the command port. The uniqueness of a handle-kind-key triple therefore follows from duplicate detection alone. They also assume that a producer holds its request steady until it is accepted. The stall property relies on `out_ready` being the only thing that can freeze the result register. The stimulus issues one command or request at a time and holds each request until `in_ready` takes it. It toggles `out_ready` only in the back-pressure scenario. The near-exhaustive sweep runs every stored key against every handle value in both key kinds. Port keys carry non-zero upper bits in that sweep, so the ignored bits are exercised on real hits.

// File: rtl/l4c_pkg.sv
package l4c_pkg;

  localparam int KEY_W   = 32;
  localparam int PORT_W  = 16;
  localparam int DEST_W  = 3;
  localparam int FLOW_W  = 8;
  localparam int QUEUE_W = 16;
  localparam int MR_W    = 8;
  localparam int SW_W    = 32;

  typedef enum logic [1:0] {
    OP_ADD    = 2'd0,
    OP_DEL    = 2'd1,
    OP_SETDEF = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_FULL     = 2'd1,
    ST_NOTFOUND = 2'd2,
    ST_BADOP    = 2'd3
  } status_e;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic [FLOW_W-1:0]  flow;
    logic [QUEUE_W-1:0] queue;
    logic [MR_W-1:0]    mroute;
    logic [SW_W-1:0]    sw0;
    logic [SW_W-1:0]    sw1;
  } route_t;

  localparam route_t RESET_DEFAULT = '{dest: 3'd4, flow: '0, queue: '0,
                                       mroute: '1, sw0: '0, sw1: '0};

  // Port keys keep only their low half; tunnel ids keep all bits.
  function automatic logic [KEY_W-1:0] norm_key(input logic kind,
                                                input logic [KEY_W-1:0] key);
    return kind ? key : {{(KEY_W-PORT_W){1'b0}}, key[PORT_W-1:0]};
  endfunction

endpackage

// File: rtl/l4c_first.sv
module l4c_first #(
  parameter  int W  = 64,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest set bit wins.
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/l4c_match.sv
module l4c_match
  import l4c_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int LINK_W  = 8
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [LINK_W-1:0]  link_tbl [ENTRIES],
  input  logic [ENTRIES-1:0] kind_tbl,
  input  logic [KEY_W-1:0]   key_tbl  [ENTRIES],
  input  logic [LINK_W-1:0]  probe_link,
  input  logic               probe_kind,
  input  logic [KEY_W-1:0]   probe_key,
  output logic [ENTRIES-1:0] hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = vld[g]
                  && (link_tbl[g] == probe_link)
                  && (kind_tbl[g] == probe_kind)
                  && (key_tbl[g]  == probe_key);
  end
endmodule

// File: rtl/l4c_table.sv
module l4c_table
  import l4c_pkg::*;
#(
  parameter  int ENTRIES = 64,
  parameter  int LINK_W  = 8,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [LINK_W-1:0]  wr_link,
  input  logic               wr_kind,
  input  logic [KEY_W-1:0]   wr_key,
  input  route_t             wr_route,
  input  logic               clr_en,
  input  logic [IW-1:0]      clr_idx,
  output logic [ENTRIES-1:0] vld,
  output logic [LINK_W-1:0]  link_tbl  [ENTRIES],
  output logic [ENTRIES-1:0] kind_tbl,
  output logic [KEY_W-1:0]   key_tbl   [ENTRIES],
  output route_t             route_tbl [ENTRIES]
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (wr_en)  vld[wr_idx]  <= 1'b1;
      if (clr_en) vld[clr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_tbl <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        link_tbl[i]  <= '0;
        key_tbl[i]   <= '0;
        route_tbl[i] <= '0;
      end
    end else if (wr_en) begin
      link_tbl[wr_idx]  <= wr_link;
      kind_tbl[wr_idx]  <= wr_kind;
      key_tbl[wr_idx]   <= wr_key;
      route_tbl[wr_idx] <= wr_route;
    end
  end

  // R6: a written slot is occupied on the next cycle
  p_wr_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_en) |=> vld[$past(wr_idx)]);

  // R9: a cleared slot is free on the next cycle
  p_clr_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en) |=> !vld[$past(clr_idx)]);
endmodule

// File: rtl/l4_link_classifier.sv
module l4_link_classifier
  import l4c_pkg::*;
#(
  parameter  int ENTRIES = 64,
  parameter  int LINK_W  = 8,
  localparam int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LINK_W-1:0]  in_link,
  input  logic               in_kind,
  input  logic [KEY_W-1:0]   in_key,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_hit,
  output logic [IW-1:0]      out_index,
  output logic [DEST_W-1:0]  out_dest,
  output logic [FLOW_W-1:0]  out_flow,
  output logic [QUEUE_W-1:0] out_queue,
  output logic [MR_W-1:0]    out_mroute,
  output logic [SW_W-1:0]    out_sw0,
  output logic [SW_W-1:0]    out_sw1,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [IW-1:0]      cmd_index,
  input  logic [LINK_W-1:0]  cmd_link,
  input  logic               cmd_kind,
  input  logic [KEY_W-1:0]   cmd_key,
  input  logic [DEST_W-1:0]  cmd_dest,
  input  logic [FLOW_W-1:0]  cmd_flow,
  input  logic [QUEUE_W-1:0] cmd_queue,
  input  logic [MR_W-1:0]    cmd_mroute,
  input  logic [SW_W-1:0]    cmd_sw0,
  input  logic [SW_W-1:0]    cmd_sw1,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [IW-1:0]      rsp_index
);

  // ---------------- table ----------------
  logic               wr_en, clr_en;
  logic [IW-1:0]      wr_idx;
  logic [ENTRIES-1:0] tbl_vld;
  logic [LINK_W-1:0]  tbl_link  [ENTRIES];
  logic [ENTRIES-1:0] tbl_kind;
  logic [KEY_W-1:0]   tbl_key   [ENTRIES];
  route_t             tbl_route [ENTRIES];
  logic [KEY_W-1:0]   cmd_key_n;
  route_t             cmd_route;

  assign cmd_key_n = norm_key(cmd_kind, cmd_key);
  assign cmd_route = '{dest: cmd_dest, flow: cmd_flow, queue: cmd_queue,
                       mroute: cmd_mroute, sw0: cmd_sw0, sw1: cmd_sw1};

  l4c_table #(.ENTRIES(ENTRIES), .LINK_W(LINK_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_link  (cmd_link),
    .wr_kind  (cmd_kind),
    .wr_key   (cmd_key_n),
    .wr_route (cmd_route),
    .clr_en   (clr_en),
    .clr_idx  (cmd_index),
    .vld      (tbl_vld),
    .link_tbl (tbl_link),
    .kind_tbl (tbl_kind),
    .key_tbl  (tbl_key),
    .route_tbl(tbl_route)
  );

  // ---------------- command path ----------------
  logic [ENTRIES-1:0] dup_hits;
  logic               dup_found, free_found;
  logic [IW-1:0]      dup_idx, free_idx;
  logic               del_ok;
  route_t             def_route;
  logic               set_def;
  status_e            nxt_status;
  logic [IW-1:0]      nxt_index;

  l4c_match #(.ENTRIES(ENTRIES), .LINK_W(LINK_W)) u_dup_match (
    .vld       (tbl_vld),
    .link_tbl  (tbl_link),
    .kind_tbl  (tbl_kind),
    .key_tbl   (tbl_key),
    .probe_link(cmd_link),
    .probe_kind(cmd_kind),
    .probe_key (cmd_key_n),
    .hits      (dup_hits)
  );

  l4c_first #(.W(ENTRIES)) u_dup_first (
    .vec(dup_hits), .found(dup_found), .idx(dup_idx)
  );

  l4c_first #(.W(ENTRIES)) u_free_first (
    .vec(~tbl_vld), .found(free_found), .idx(free_idx)
  );

  assign cmd_ready = 1'b1;
  assign del_ok    = (int'(cmd_index) < ENTRIES) && tbl_vld[cmd_index];

  always_comb begin
    wr_en      = 1'b0;
    clr_en     = 1'b0;
    set_def    = 1'b0;
    wr_idx     = '0;
    nxt_status = ST_BADOP;
    nxt_index  = '0;
    if (cmd_valid) begin
      case (op_e'(cmd_op))
        OP_ADD: begin
          if (dup_found) begin
            wr_en      = 1'b1;
            wr_idx     = dup_idx;
            nxt_status = ST_OK;
            nxt_index  = dup_idx;
          end else if (free_found) begin
            wr_en      = 1'b1;
            wr_idx     = free_idx;
            nxt_status = ST_OK;
            nxt_index  = free_idx;
          end else begin
            nxt_status = ST_FULL;
          end
        end
        OP_DEL: begin
          nxt_index = cmd_index;
          if (del_ok) begin
            clr_en     = 1'b1;
            nxt_status = ST_OK;
          end else begin
            nxt_status = ST_NOTFOUND;
          end
        end
        OP_SETDEF: begin
          set_def    = 1'b1;
          nxt_status = ST_OK;
        end
        default: nxt_status = ST_BADOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_index  <= '0;
      def_route  <= RESET_DEFAULT;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        rsp_status <= nxt_status;
        rsp_index  <= nxt_index;
      end
      if (set_def) def_route <= cmd_route;
    end
  end

  // R7: duplicate detection keeps every handle/kind/key triple unique
  p_unique_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dup_hits));

  // R8: a full status is only ever reported with every slot occupied
  p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_FULL) |-> (&tbl_vld));

  // R12: one response per command, on the following cycle
  p_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  p_norsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);

  // ---------------- lookup pipeline ----------------
  logic               s1_v;
  logic [LINK_W-1:0]  s1_link;
  logic               s1_kind;
  logic [KEY_W-1:0]   s1_key;
  logic               adv;
  logic [ENTRIES-1:0] lk_hits;
  logic               lk_found;
  logic [IW-1:0]      lk_idx;
  logic               o_v, o_hit;
  logic [IW-1:0]      o_idx;
  route_t             o_route;

  assign adv      = !o_v || out_ready;
  assign in_ready = !s1_v || adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_link <= '0;
      s1_kind <= 1'b0;
      s1_key  <= '0;
    end else if (in_ready) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_link <= in_link;
        s1_kind <= in_kind;
        s1_key  <= norm_key(in_kind, in_key);
      end
    end
  end

  l4c_match #(.ENTRIES(ENTRIES), .LINK_W(LINK_W)) u_lk_match (
    .vld       (tbl_vld),
    .link_tbl  (tbl_link),
    .kind_tbl  (tbl_kind),
    .key_tbl   (tbl_key),
    .probe_link(s1_link),
    .probe_kind(s1_kind),
    .probe_key (s1_key),
    .hits      (lk_hits)
  );

  l4c_first #(.W(ENTRIES)) u_lk_first (
    .vec(lk_hits), .found(lk_found), .idx(lk_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_v     <= 1'b0;
      o_hit   <= 1'b0;
      o_idx   <= '0;
      o_route <= '0;
    end else if (adv) begin
      o_v <= s1_v;
      if (s1_v) begin
        o_hit   <= lk_found;
        o_idx   <= lk_found ? lk_idx : '0;
        o_route <= lk_found ? tbl_route[lk_idx] : def_route;
      end
    end
  end

  assign out_valid  = o_v;
  assign out_hit    = o_hit;
  assign out_index  = o_idx;
  assign out_dest   = o_route.dest;
  assign out_flow   = o_route.flow;
  assign out_queue  = o_route.queue;
  assign out_mroute = o_route.mroute;
  assign out_sw0    = o_route.sw0;
  assign out_sw1    = o_route.sw1;

  // R10: an occupied first stage reaches the output when the consumer takes
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && out_ready) |=> out_valid);

  // R11: a stalled result does not change
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit)
      && $stable(out_index) && $stable(out_queue) && $stable(out_sw0)
      && $stable(out_dest)));

endmodule

// File: tb/l4_link_classifier_test.sv
module l4_link_classifier_test;
  import l4c_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int LW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic in_valid = 1'b0, in_ready, in_kind = 1'b0;
  logic [LW-1:0] in_link = '0;
  logic [31:0] in_key = '0;
  logic out_valid, out_ready = 1'b1, out_hit;
  logic [IW-1:0] out_index;
  logic [2:0] out_dest;
  logic [7:0] out_flow, out_mroute;
  logic [15:0] out_queue;
  logic [31:0] out_sw0, out_sw1;
  logic cmd_valid = 1'b0, cmd_ready, cmd_kind = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [IW-1:0] cmd_index = '0;
  logic [LW-1:0] cmd_link = '0;
  logic [31:0] cmd_key = '0;
  route_t cmd_r = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [IW-1:0] rsp_index;

  l4_link_classifier #(.ENTRIES(N), .LINK_W(LW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_link(in_link),
    .in_kind(in_kind), .in_key(in_key),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_index(out_index), .out_dest(out_dest), .out_flow(out_flow),
    .out_queue(out_queue), .out_mroute(out_mroute), .out_sw0(out_sw0),
    .out_sw1(out_sw1),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_index(cmd_index), .cmd_link(cmd_link), .cmd_kind(cmd_kind),
    .cmd_key(cmd_key), .cmd_dest(cmd_r.dest), .cmd_flow(cmd_r.flow),
    .cmd_queue(cmd_r.queue), .cmd_mroute(cmd_r.mroute),
    .cmd_sw0(cmd_r.sw0), .cmd_sw1(cmd_r.sw1),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_index(rsp_index)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model of the table
  bit          m_v    [N];
  logic [LW-1:0] m_link [N];
  bit          m_kind [N];
  logic [31:0] m_key  [N];
  route_t      m_route[N];
  route_t      m_def;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic route_t mk_route(input int i);
    route_t r;
    r.dest   = 3'(i % 6);
    r.flow   = 8'(10 + i);
    r.queue  = 16'(900 + i);
    r.mroute = (i == 0) ? 8'hFF : 8'(i);
    r.sw0    = 32'h5000_0000 + 32'(i);
    r.sw1    = ~(32'h5000_0000 + 32'(i));
    return r;
  endfunction

  function automatic logic [31:0] nk(input bit kind, input logic [31:0] key);
    return kind ? key : {16'h0, key[15:0]};
  endfunction

  function automatic int exp_find(input logic [LW-1:0] link, input bit kind, input logic [31:0] key);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_link[i] == link && m_kind[i] == kind && m_key[i] == nk(kind, key))
        return i;
    return -1;
  endfunction

  function automatic route_t out_route();
    return '{dest: out_dest, flow: out_flow, queue: out_queue,
             mroute: out_mroute, sw0: out_sw0, sw1: out_sw1};
  endfunction

  task automatic send_cmd(input logic [1:0] op, input logic [IW-1:0] idx,
                          input logic [LW-1:0] link, input bit kind,
                          input logic [31:0] key, input route_t r,
                          input string req, input logic [1:0] est, input logic [IW-1:0] eidx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_index = idx; cmd_link = link;
    cmd_kind = kind; cmd_key = key; cmd_r = r;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " status"}, rsp_status, est);
    chk({req, " index"}, rsp_index, eidx);
  endtask

  task automatic add(input string req, input logic [LW-1:0] link, input bit kind,
                     input logic [31:0] key, input route_t r);
    int e, f;
    e = exp_find(link, kind, key);
    f = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) f = i;
    if (e >= 0) begin
      m_route[e] = r;
      send_cmd(OP_ADD, '0, link, kind, key, r, req, ST_OK, IW'(e));
    end else if (f >= 0) begin
      m_v[f] = 1; m_link[f] = link; m_kind[f] = kind; m_key[f] = nk(kind, key); m_route[f] = r;
      send_cmd(OP_ADD, '0, link, kind, key, r, req, ST_OK, IW'(f));
    end else begin
      send_cmd(OP_ADD, '0, link, kind, key, r, req, ST_FULL, '0);
    end
  endtask

  task automatic del(input string req, input int idx);
    logic [1:0] est;
    est = m_v[idx] ? ST_OK : ST_NOTFOUND;
    m_v[idx] = 0;
    send_cmd(OP_DEL, IW'(idx), '0, 0, '0, '0, req, est, IW'(idx));
  endtask

  // one request with out_ready high; checks the two-edge latency (R10)
  task automatic look(input string req, input logic [LW-1:0] link, input bit kind,
                      input logic [31:0] key);
    int e;
    route_t er;
    e = exp_find(link, kind, key);
    er = (e >= 0) ? m_route[e] : m_def;
    @(negedge clk);
    in_valid = 1'b1; in_link = link; in_kind = kind; in_key = key;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 not yet valid", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 valid after second edge", out_valid, 1);
    chk({req, " hit"}, out_hit, (e >= 0));
    chk({req, " index"}, out_index, (e >= 0) ? IW'(e) : '0);
    chk({req, " route"}, out_route(), er);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    route_t a, b;
    logic [31:0] k;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_def = RESET_DEFAULT;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 out_valid", out_valid, 0);
    chk("R13 rsp_valid", rsp_valid, 0);
    chk("R13 in_ready", in_ready, 1);
    chk("R12 cmd_ready", cmd_ready, 1);
    look("R5 reset default miss", 4'd3, 0, 32'h1234);
    look("R13 empty table", 4'd0, 1, 32'h0);

    // R6 fill every slot; port keys carry junk upper bits (R1)
    for (int i = 0; i < N; i++) begin
      k = (i % 2) ? (32'h0000_0800 + 32'(i)) : (32'h7777_0800 + 32'(i));
      add("R6 fill", LW'(2 * i), bit'(i % 2), k, mk_route(i));
    end

    // near-exhaustive sweep: every key against every handle, both kinds
    for (int l = 0; l < (1 << LW); l++) begin
      for (int e = 0; e < N; e++) begin
        k = m_kind[e] ? m_key[e] : (m_key[e] | 32'hBEEF_0000);
        look("R3 handle sweep R1 upper bits", LW'(l), m_kind[e], k);
        look("R2 kind cross", LW'(l), !m_kind[e], m_key[e]);
      end
    end
    look("R2 tunnel upper bits matter", 4'd2, 1, 32'h0001_0801);
    look("R4 tunnel hit", 4'd6, 1, 32'h0000_0803);

    // R8 full table
    add("R8 full", 4'd1, 0, 32'h0000_4444, mk_route(20));
    look("R8 rejected key misses", 4'd1, 0, 32'h0000_4444);

    // R7 duplicate rewrites in place
    add("R7 duplicate", 4'd6, 1, 32'h0000_0803, mk_route(30));
    look("R7 new route", 4'd6, 1, 32'h0000_0803);
    add("R7 duplicate port other upper bits", 4'd0, 0, 32'h0000_0800, mk_route(31));
    look("R7 port rewritten", 4'd0, 0, 32'hFFFF_0800);

    // R9 delete
    del("R9 delete occupied", 2);
    look("R9 deleted misses", 4'd4, 0, 32'h0000_0802);
    del("R9 delete free", 2);
    add("R6 reuse freed slot", 4'd9, 0, 32'h0000_5555, mk_route(40));
    look("R6 reused slot hit", 4'd9, 0, 32'h0000_5555);

    // R5 set default
    a = mk_route(50);
    a.dest = 3'd5;
    m_def = a;
    send_cmd(OP_SETDEF, '0, '0, 0, '0, a, "R5 set default", ST_OK, '0);
    look("R5 new default", 4'd15, 1, 32'hFFFF_FFFF);

    // R12 reserved op changes nothing, one-cycle pulse
    send_cmd(OP_RSVD, 3'd1, 4'd1, 0, 32'h0000_0801, '0, "R12 reserved", ST_BADOP, '0);
    @(negedge clk);
    chk("R12 pulse ends", rsp_valid, 0);
    look("R12 table untouched", 4'd2, 1, 32'h0000_0801);

    // R11 back-pressure, R10 order
    a = m_route[1];
    b = m_route[3];
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_link = 4'd2; in_kind = 1; in_key = 32'h0000_0801;
    @(posedge clk);
    @(negedge clk);
    in_link = 4'd6; in_key = 32'h0000_0803;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 out_valid stalled", out_valid, 1);
    chk("R11 in_ready low", in_ready, 0);
    chk("R11 first result", out_route(), a);
    @(posedge clk);
    @(negedge clk);
    chk("R11 held index", out_index, 3'd1);
    chk("R11 held route", out_route(), a);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 second in order", out_index, 3'd3);
    chk("R10 second route", out_route(), b);
    @(posedge clk);
    @(negedge clk);
    chk("R10 drained", out_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule